// File: doc/BRIEF.md
# Page Latch and Erase/Write Sequencer

This block sits behind the serial-bus protocol controller of a small non-volatile memory. During a write transfer the controller hands it the word address and then each received data byte. The block holds up to eight bytes in a byte latch and tells the controller whether the current byte may be acknowledged. When the STOP condition arrives it runs a timed programming cycle and commits the latched bytes to the memory array model through a single-cycle write port. A full page of eight bytes takes one erase step and then eight write steps. A shorter transfer takes one write step per byte. While the cycle runs, `busy_o` tells the controller to withhold acknowledge, and every bus-side input is ignored.

Each step is timed by one of two sources. The internal source is a system-clock divider feeding a step timer. The external source is a pin that is sampled when the word address is loaded; if that pin reads low, each rising edge on it ends one step. A transfer that receives more than eight data bytes is dropped completely. A transfer with no data bytes starts no cycle at all.

Top module: `ee_page_sequencer`

## Requirements
- R1: `accept_o` is 1 while collecting and fewer than PAGE_BYTES (8) bytes have been latched. For the ninth data byte and every byte after it, `accept_o` is 0.
- R2: If more than PAGE_BYTES data bytes arrive before `stop_i`, the stop starts no cycle. `busy_o` stays 0 and no strobe of either kind appears.
- R3: A stop that follows an address load with no data bytes leaves `busy_o` at 0 and produces no strobe.
- R4: Data byte i, counted from 0, is written to address {base[7:3], (base[2:0]+i) mod 8}. Only the low three address bits advance.
- R5: A transfer of n bytes, with 1 ≤ n ≤ 7, gives exactly n write strobes and no erase strobe, in arrival order. In internal mode, strobe k appears (k+1)·DIV·TICKS+1 cycle counts after the edge that samples stop.
- R6: A transfer of exactly 8 bytes gives one erase strobe first, at address {base[7:3],3'b000}, followed by 8 write strobes. That is 9 equally spaced steps.
- R7: `busy_o` rises in the cycle after the edge that samples `stop_i`. It stays 1 until the last strobe and is 0 in the cycle in which the last strobe is visible.
- R8: While `busy_o` is 1, `addr_load_i`, `byte_valid_i` and `stop_i` have no effect. `accept_o` is 0, the strobes of the running cycle are unchanged, and no further cycle starts.
- R9: If `ptc_i` is 0 when the address is loaded, external mode is selected. No step ends without a pulse, and each rising edge of `ptc_i` ends exactly one step.
- R10: A strobe lasts one cycle, and `prog_we_o` and `prog_erase_o` are never high together.
- R11: After reset, `busy_o`, `accept_o`, `prog_we_o` and `prog_erase_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Pulse: the word address is complete; also samples the timing-source pin |
| addr_i | input | ADDR_W | Word address of the transfer |
| ptc_i | input | 1 | Programming-time-control pin: low at address load selects external timing; its rising edges then end steps |
| byte_valid_i | input | 1 | Pulse: a data byte has been received |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Pulse: STOP condition seen |
| accept_o | output | 1 | The byte now arriving may be acknowledged |
| busy_o | output | 1 | Programming cycle in progress |
| prog_we_o | output | 1 | One-cycle write strobe to the array |
| prog_erase_o | output | 1 | One-cycle page erase strobe to the array |
| prog_addr_o | output | ADDR_W | Array address for the strobe |
| prog_data_o | output | 8 | Array data for a write strobe |

## Verification
The assertions check, on every cycle, the properties that hold at all times. These are: the strobes are exclusive and last one cycle; strobes occur only inside a busy cycle; busy starts only from a stop; the latch count never passes the page size; an erase targets a page-aligned address; and a stop after overflow never starts a cycle. Only the bench's scenarios can show the rest. That covers the order and addresses of the strobes, address wrap inside the eight-byte window, and the exact step spacing. It also covers the external-pin pacing, the silent dropping of overflowed and empty transfers, and the fact that activity on the bus during a cycle changes nothing.

// File: rtl/ee_seq_pkg.sv
package ee_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_PROG
  } seq_state_e;
endpackage

// File: rtl/ee_byte_latch.sv
module ee_byte_latch #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    din_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [7:0]    slot_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full;

  assign full = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (push_i) begin
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i && !full && !ovf_q)
      slot_q[cnt_q[IW-1:0]] <= din_i;
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign ovf_o     = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(cnt_q) == CW'(DEPTH)); // R2
endmodule

// File: rtl/ee_step_timer.sv
module ee_step_timer #(
  parameter int DIV   = 128,
  parameter int TICKS = 16,
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ext_i,
  input  logic ptc_i,
  output logic step_o
);
  logic [DW-1:0] div_q;
  logic [TW-1:0] tm_q;
  logic [2:0]    sync_q;
  logic          div_last, tm_last, ptc_rise;

  assign div_last = (div_q == DW'(DIV - 1));
  assign tm_last  = (tm_q == TW'(TICKS - 1));
  assign ptc_rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tm_q  <= '0;
    end else if (!run_i) begin
      div_q <= '0;
      tm_q  <= '0;
    end else begin
      div_q <= div_last ? '0 : div_q + DW'(1);
      if (div_last) tm_q <= tm_last ? '0 : tm_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], ptc_i};
  end

  assign step_o = run_i && (ext_i ? ptc_rise : (div_last && tm_last));

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o); // R10
endmodule

// File: rtl/ee_page_sequencer.sv
module ee_page_sequencer
  import ee_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int DIV        = 128,
  parameter int TICKS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ptc_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              prog_we_o,
  output logic              prog_erase_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int SW = $clog2(PAGE_BYTES + 2);

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IW-1:0] idx);
    logic [ADDR_W-1:0] a;
    a = base;
    a[IW-1:0] = base[IW-1:0] + idx;
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] page_base(input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] a;
    a = base;
    a[IW-1:0] = '0;
    return a;
  endfunction

  function automatic logic [SW-1:0] step_total(input logic [CW-1:0] n);
    return (n == CW'(PAGE_BYTES)) ? SW'(PAGE_BYTES + 1) : SW'(n);
  endfunction

  seq_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic              ext_q;
  logic [SW-1:0]     sidx_q;
  logic              we_q, erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  logic [CW-1:0] cnt;
  logic          ovf, step;
  logic [7:0]    rd_data;
  logic          take_addr, take_byte, take_stop, start_prog;
  logic          is_page, erase_step, last_step;
  logic [SW-1:0] bidx_full;
  logic [IW-1:0] bidx;

  assign take_addr  = addr_load_i && (state_q != ST_PROG);
  assign take_byte  = byte_valid_i && (state_q == ST_FILL);
  assign take_stop  = stop_i && (state_q == ST_FILL);
  assign start_prog = take_stop && (cnt != '0) && !ovf;
  assign is_page    = (cnt == CW'(PAGE_BYTES));
  assign erase_step = is_page && (sidx_q == '0);
  assign bidx_full  = is_page ? sidx_q - SW'(1) : sidx_q;
  assign bidx       = bidx_full[IW-1:0];
  assign last_step  = (sidx_q == step_total(cnt) - SW'(1));

  ee_byte_latch #(.DEPTH(PAGE_BYTES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (take_addr),
    .push_i    (take_byte),
    .din_i     (byte_i),
    .rd_idx_i  (bidx),
    .rd_data_o (rd_data),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  ee_step_timer #(.DIV(DIV), .TICKS(TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state_q == ST_PROG),
    .ext_i  (ext_q),
    .ptc_i  (ptc_i),
    .step_o (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ext_q   <= 1'b0;
      sidx_q  <= '0;
      we_q    <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q    <= 1'b0;
      erase_q <= 1'b0;
      case (state_q)
        ST_IDLE, ST_FILL: begin
          if (take_addr) begin
            state_q <= ST_FILL;
            base_q  <= addr_i;
            ext_q   <= !ptc_i;
            sidx_q  <= '0;
          end else if (take_stop) begin
            state_q <= start_prog ? ST_PROG : ST_IDLE;
          end
        end
        ST_PROG: begin
          if (step) begin
            if (erase_step) begin
              erase_q <= 1'b1;
              addr_q  <= page_base(base_q);
              data_q  <= '0;
            end else begin
              we_q   <= 1'b1;
              addr_q <= slot_addr(base_q, bidx);
              data_q <= rd_data;
            end
            sidx_q <= sidx_q + SW'(1);
            if (last_step) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == ST_PROG);
  assign accept_o     = (state_q == ST_FILL) && !ovf && !is_page;
  assign prog_we_o    = we_q;
  assign prog_erase_o = erase_q;
  assign prog_addr_o  = addr_q;
  assign prog_data_o  = data_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && erase_q)); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q || erase_q) |=> !(we_q || erase_q)); // R10
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i)); // R7
  AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q || erase_q) |-> $past(busy_o)); // R7
  AST_BUSY_IGNORES_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && byte_valid_i) |=> $stable(cnt)); // R8
  AST_DROP_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && stop_i && !addr_load_i && ovf) |=> !busy_o); // R2
  AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |-> (addr_q[IW-1:0] == '0)); // R6
endmodule

// File: tb/sim_ee_page_sequencer.sv
module sim_ee_page_sequencer;
  localparam int DIV   = 4;
  localparam int TICKS = 4;
  localparam int STEP  = DIV * TICKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic       ptc_i = 1'b1;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       stop_i = 1'b0;
  logic       accept_o, busy_o, prog_we_o, prog_erase_o;
  logic [7:0] prog_addr_o, prog_data_o;

  int tests = 0;
  int fails = 0;
  int cyc_e = 0;
  int stop_e = 0;
  int wd = 0;
  bit done = 0;

  int         lg_n = 0;
  int         lg_cyc [256];
  bit         lg_er  [256];
  logic [7:0] lg_addr[256];
  logic [7:0] lg_data[256];
  bit         lg_busy[256];
  logic [7:0] xd[16];

  always #4 clk = ~clk;

  ee_page_sequencer #(.ADDR_W(8), .PAGE_BYTES(8), .DIV(DIV), .TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .ptc_i(ptc_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i), .stop_i(stop_i),
    .accept_o(accept_o), .busy_o(busy_o), .prog_we_o(prog_we_o),
    .prog_erase_o(prog_erase_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o)
  );

  always @(posedge clk) begin
    cyc_e <= cyc_e + 1;
    if (stop_i) stop_e <= cyc_e;
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=%0d", wd, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (prog_we_o || prog_erase_o) begin
      if (lg_n < 256) begin
        lg_cyc[lg_n]  = cyc_e;
        lg_er[lg_n]   = prog_erase_o;
        lg_addr[lg_n] = prog_addr_o;
        lg_data[lg_n] = prog_data_o;
        lg_busy[lg_n] = busy_o;
      end
      lg_n = lg_n + 1;
    end
  end

  function automatic logic [7:0] exp_addr(input logic [7:0] base, input int i);
    logic [7:0] lo;
    lo = 8'(int'(base[2:0]) + i);
    return {base[7:3], lo[2:0]};
  endfunction

  function automatic int exp_steps(input int n);
    if (n == 8) return 9;
    if (n > 8) return 0;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [7:0] base, input int n, input bit ext, output int xs);
    @(negedge clk);
    ptc_i = ext ? 1'b0 : 1'b1;
    addr_load_i = 1'b1;
    addr_i = base;
    @(negedge clk);
    addr_load_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(accept_o == (i < 8), "R1 accept per byte", int'(accept_o), int'(i < 8));
      byte_valid_i = 1'b1;
      byte_i = xd[i];
      @(negedge clk);
      byte_valid_i = 1'b0;
      @(negedge clk);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    xs = stop_e;
    chk(busy_o == (n >= 1 && n <= 8), "R7 busy after stop (R2/R3 when dropped)",
        int'(busy_o), int'(n >= 1 && n <= 8));
  endtask

  task automatic verify(input logic [7:0] base, input int n, input int b,
                        input int xs, input bit timed);
    int ns;
    ns = exp_steps(n);
    chk(lg_n - b == ns, "R5/R6 strobe count", lg_n - b, ns);
    for (int k = 0; k < ns && k < lg_n - b; k++) begin
      int idx;
      int di;
      bit er;
      idx = b + k;
      er = (n == 8 && k == 0);
      di = (n == 8) ? k - 1 : k;
      chk(lg_er[idx] == er, "R6 erase first / R5 no erase", int'(lg_er[idx]), int'(er));
      if (er)
        chk(lg_addr[idx] == {base[7:3], 3'b000}, "R6 erase page address",
            int'(lg_addr[idx]), int'({base[7:3], 3'b000}));
      else begin
        chk(lg_addr[idx] == exp_addr(base, di), "R4 wrapped write address",
            int'(lg_addr[idx]), int'(exp_addr(base, di)));
        chk(lg_data[idx] == xd[di], "R5 write data order", int'(lg_data[idx]), int'(xd[di]));
      end
      if (timed)
        chk(lg_cyc[idx] - xs == (k + 1) * STEP + 1, "R5 step spacing",
            lg_cyc[idx] - xs, (k + 1) * STEP + 1);
      chk(lg_busy[idx] == (k != ns - 1), "R7 busy until last strobe",
          int'(lg_busy[idx]), int'(k != ns - 1));
    end
    chk(busy_o == 1'b0, "R7 busy low after cycle", int'(busy_o), 0);
  endtask

  initial begin
    int xs;
    int b;
    int seed;
    logic [7:0] base;
    int n;
    seed = int'($urandom(32'd1357));

    cycles(3);
    chk(busy_o == 0 && accept_o == 0, "R11 reset outputs idle", int'({busy_o, accept_o}), 0);
    chk(prog_we_o == 0 && prog_erase_o == 0, "R11 reset strobes low",
        int'({prog_we_o, prog_erase_o}), 0);
    rst_n = 1'b1;
    cycles(2);

    // R6 directed full page with wrap start
    for (int i = 0; i < 8; i++) xd[i] = 8'(8'h10 + i);
    b = lg_n;
    run_xfer(8'h5D, 8, 1'b0, xs);
    cycles(9 * STEP + 6);
    verify(8'h5D, 8, b, xs, 1'b1);

    // R5 constrained random partial and full transfers
    for (int t = 0; t < 6; t++) begin
      base = 8'($urandom);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) xd[i] = 8'($urandom);
      b = lg_n;
      run_xfer(base, n, 1'b0, xs);
      cycles(exp_steps(n) * STEP + 6);
      verify(base, n, b, xs, 1'b1);
    end

    // R3 empty transfer
    b = lg_n;
    run_xfer(8'h20, 0, 1'b0, xs);
    cycles(3 * STEP);
    chk(lg_n == b, "R3 empty makes no strobe", lg_n - b, 0);
    chk(busy_o == 0, "R3 empty never busy", int'(busy_o), 0);

    // R2 overflow with nine and ten bytes
    for (int extra = 9; extra <= 10; extra++) begin
      for (int i = 0; i < 10; i++) xd[i] = 8'($urandom);
      b = lg_n;
      run_xfer(8'h40, extra, 1'b0, xs);
      cycles(10 * STEP);
      chk(lg_n == b, "R2 overflow drops transfer", lg_n - b, 0);
      chk(busy_o == 0, "R2 overflow not busy", int'(busy_o), 0);
    end

    // R8 bus activity during busy is ignored
    xd[0] = 8'hA1; xd[1] = 8'hB2;
    b = lg_n;
    run_xfer(8'h86, 2, 1'b0, xs);
    cycles(3);
    chk(accept_o == 0, "R8 no accept while busy", int'(accept_o), 0);
    addr_load_i = 1'b1; addr_i = 8'h00; ptc_i = 1'b0;
    @(negedge clk);
    addr_load_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'hEE;
    @(negedge clk);
    byte_valid_i = 1'b0; stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0; ptc_i = 1'b1;
    cycles(2 * STEP);
    verify(8'h86, 2, b, xs, 1'b1);
    cycles(3 * STEP);
    chk(lg_n - b == 2, "R8 no extra cycle from stop during busy", lg_n - b, 2);

    // R9 external pulse timing
    xd[0] = 8'h3C; xd[1] = 8'h4D; xd[2] = 8'h5E;
    b = lg_n;
    run_xfer(8'hF6, 3, 1'b1, xs);
    cycles(3 * STEP);
    chk(lg_n == b, "R9 no step without pulse", lg_n - b, 0);
    chk(busy_o == 1, "R9 still busy waiting for pulse", int'(busy_o), 1);
    for (int j = 1; j <= 3; j++) begin
      ptc_i = 1'b1;
      cycles(3);
      ptc_i = 1'b0;
      cycles(7);
      chk(lg_n - b == j, "R9 one step per pulse", lg_n - b, j);
    end
    verify(8'hF6, 3, b, xs, 1'b0);
    ptc_i = 1'b1;
    cycles(4);

    // R1/R5 fresh transfer still works afterwards
    xd[0] = 8'h77;
    b = lg_n;
    run_xfer(8'h07, 1, 1'b0, xs);
    cycles(STEP + 6);
    verify(8'h07, 1, b, xs, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule